// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Register File

This block is a slave on a three-wire serial link: one clock line, one active-low select line and one shared bidirectional data line. It holds a small file of byte-wide configuration registers. The rest of the chip consumes these registers through a flat output vector. Each transaction opens with a 16-bit instruction. The top bit of the instruction marks a read, and the low 13 bits give a register address. Data bytes follow, and the address advances by one after every byte for as long as the select line stays low.

Writes to the configuration registers go into a shadow (buffer) bank. The values the device actually uses change only when software sets a self-clearing transfer bit, which copies the whole shadow bank into the active bank in one step. A readback selector chooses whether reads return the active values or the staged ones. A control register sets the shift order, most-significant-first or least-significant-first, and that choice applies from the next transaction on. The same register holds a self-clearing soft reset and two fixed bits: one that reports the mode as three-wire only and one that reports 16-bit instructions only. The low nibble of that register always reads back as a bit-reversed copy of the high nibble, so it decodes the same way in either shift order.

The serial inputs are oversampled by the system clock through two-stage synchronizers, so the serial clock must be several times slower than the system clock.

Top module: `dbuf_cfg_regs`

## Requirements
- R1: An instruction is 16 bits. Bit 15 = 1 means read and 0 means write, bits 14:13 are ignored, and bits 12:0 are the address. Data bits are sampled on the rising edge of the serial clock. Each following data byte goes to the next address while the select line stays low.
- R2: A write to a configuration register (addresses BASE_ADDR to BASE_ADDR+NUM_REGS-1, default 0x0A to 0x0D) changes only its buffer. The active outputs stay the same.
- R3: Writing a byte with bit 0 = 1 to address 0x05 copies every buffer into the active registers in one step. Address 0x05 always reads 0.
- R4: Address 0x04 bit 0 selects the readback source: 0 (the reset value) returns active values, 1 returns buffered values. It reads back as written.
- R5: Address 0x00 bit 6 sets the shift order. 0 (the reset value) means the most significant bit goes first, and the 16-bit instruction is sent bit 15 first. 1 means the least significant bit goes first, and the instruction is sent bit 0 first. A new setting takes effect from the next transaction, never within the current one.
- R6: Writing a byte with bit 5 = 1 to address 0x00 returns the buffers, the active registers, the shift order and the readback selector to their reset values. Bit 5 always reads 0.
- R7: A read of address 0x00 returns bit 7 = 0 (three-wire only) and bit 4 = 1 (16-bit instructions only). Bit 3-k equals bit 4+k for k = 0..3, so the value is 0x18, or 0x5A when bit 6 is set.
- R8: Addresses with no function read as 0x00, and writes to them change nothing.
- R9: The block drives the data line only during the data phase of a read while the select line is low. Otherwise it is released. Read bits change on the falling edge of the serial clock.
- R10: After the synchronous reset the active outputs equal REG_DEFAULTS (default: 0x80 at 0x0A, 0x30 at 0x0B, 0x00 above).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which also oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idle low |
| csb | input | 1 | Active-low transaction select |
| sdio | inout | 1 | Bidirectional serial data |
| active_o | output | NUM_REGS*8 | Active register values, register at BASE_ADDR in bits 7:0 |

## Verification
A wrong shadow or active bank shows on active_o in the system-clock cycle after the transfer bit is written, and in any readback of the same address. Staged-versus-applied readback in both selector states separates the two banks. A bit-order flag that changes mid-frame corrupts later bytes of the same frame. The bench catches this by writing the readback selector in the same frame that sets least-significant-first and reading it back in the next frame. A data line that stays driven outside a read shows up as soon as the bench drives it while the select line is high.

// File: rtl/dbuf_cfg_pkg.sv
package dbuf_cfg_pkg;
  localparam int BYTE_W  = 8;
  localparam int INSTR_W = 16;

  typedef enum logic {
    PH_INSTR = 1'b0,
    PH_DATA  = 1'b1
  } phase_t;
endpackage

// File: rtl/dbuf_cfg_link.sv
module dbuf_cfg_link
  import dbuf_cfg_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              csb_i,
  input  logic              sdi_i,
  input  logic              lsb_first_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              oe_o
);
  localparam int CNT_W = $clog2(INSTR_W);
  localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(BYTE_W - 1);

  logic [2:0] sclk_s;
  logic [1:0] csb_s, sdi_s;
  logic       rise, fall, sel;

  phase_t               phase;
  logic [CNT_W-1:0]     cnt;
  logic [INSTR_W-1:0]   sh, sh_next;
  logic [BYTE_W-1:0]    tx, byte_next;
  logic [ADDR_W-1:0]    addr_q;
  logic                 rw_q, lsb_q, load_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s <= '0;
      csb_s  <= '1;
      sdi_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      csb_s  <= {csb_s[0], csb_i};
      sdi_s  <= {sdi_s[0], sdi_i};
    end
  end

  assign rise = sclk_s[1] & ~sclk_s[2];
  assign fall = ~sclk_s[1] & sclk_s[2];
  assign sel  = ~csb_s[1];

  assign sh_next   = lsb_q ? {sdi_s[1], sh[INSTR_W-1:1]} : {sh[INSTR_W-2:0], sdi_s[1]};
  assign byte_next = lsb_q ? sh_next[INSTR_W-1 -: BYTE_W] : sh_next[BYTE_W-1:0];
  assign rd_addr_o = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_INSTR;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      addr_q    <= '0;
      rw_q      <= 1'b0;
      lsb_q     <= 1'b0;
      load_pend <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      sdo_o     <= 1'b0;
      oe_o      <= 1'b0;
    end else begin
      wr_stb_o  <= 1'b0;
      load_pend <= 1'b0;
      if (!sel) begin
        phase <= PH_INSTR;
        cnt   <= '0;
        oe_o  <= 1'b0;
        lsb_q <= lsb_first_i;
      end else begin
        if (rise) begin
          sh  <= sh_next;
          cnt <= cnt + 1'b1;
          if (phase == PH_INSTR && cnt == INSTR_LAST) begin
            rw_q   <= sh_next[INSTR_W-1];
            addr_q <= sh_next[ADDR_W-1:0];
            phase  <= PH_DATA;
            cnt    <= '0;
            if (sh_next[INSTR_W-1]) begin
              oe_o      <= 1'b1;
              load_pend <= 1'b1;
            end
          end else if (phase == PH_DATA && cnt == BYTE_LAST) begin
            cnt    <= '0;
            addr_q <= addr_q + 1'b1;
            if (rw_q) begin
              load_pend <= 1'b1;
            end else begin
              wr_stb_o  <= 1'b1;
              wr_addr_o <= addr_q;
              wr_data_o <= byte_next;
            end
          end
        end
        if (fall && phase == PH_DATA && rw_q) begin
          sdo_o <= lsb_q ? tx[0] : tx[BYTE_W-1];
          tx    <= lsb_q ? (tx >> 1) : (tx << 1);
        end
        if (load_pend) tx <= rd_data_i;
      end
    end
  end

  // R9: data line released one cycle after select goes inactive
  assert_release_idle_R9: assert property (@(posedge clk) disable iff (rst)
    csb_s[1] |=> !oe_o);
  // R9: driving only happens inside a read transaction
  assert_drive_read_only_R9: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> rw_q);
  // R1: a write byte produces a one-cycle strobe
  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);
endmodule

// File: rtl/dbuf_cfg_bank.sv
module dbuf_cfg_bank
  import dbuf_cfg_pkg::*;
#(
  parameter int                         NUM_REGS = 4,
  parameter int                         IDX_W    = 2,
  parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear_i,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [BYTE_W-1:0]            wr_data_i,
  input  logic                         commit_i,
  output logic [NUM_REGS*BYTE_W-1:0]   buf_o,
  output logic [NUM_REGS*BYTE_W-1:0]   act_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst || clear_i) begin
        buf_o[g*BYTE_W +: BYTE_W] <= DEFAULTS[g*BYTE_W +: BYTE_W];
        act_o[g*BYTE_W +: BYTE_W] <= DEFAULTS[g*BYTE_W +: BYTE_W];
      end else begin
        if (wr_en_i && wr_idx_i == IDX_W'(g))
          buf_o[g*BYTE_W +: BYTE_W] <= wr_data_i;
        if (commit_i)
          act_o[g*BYTE_W +: BYTE_W] <= buf_o[g*BYTE_W +: BYTE_W];
      end
    end
  end

  // R3: commit copies the whole shadow bank
  assert_commit_copy_R3: assert property (@(posedge clk) disable iff (rst)
    commit_i && !clear_i |=> act_o == $past(buf_o));
  // R2: active bank holds between commits
  assert_active_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !commit_i && !clear_i |=> $stable(act_o));
  // R6: soft reset restores both banks
  assert_clear_defaults_R6: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (act_o == DEFAULTS) && (buf_o == DEFAULTS));
endmodule

// File: rtl/dbuf_cfg_regs.sv
module dbuf_cfg_regs
  import dbuf_cfg_pkg::*;
#(
  parameter int                         ADDR_W       = 13,
  parameter int                         NUM_REGS     = 4,
  parameter int                         BASE_ADDR    = 10,
  parameter logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS = 32'h0000_3080
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sclk,
  input  logic                       csb,
  inout  wire                        sdio,
  output logic [NUM_REGS*BYTE_W-1:0] active_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RBSEL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_XFER  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_NUM   = ADDR_W'(NUM_REGS);

  logic [ADDR_W-1:0] rd_addr, wr_addr, rd_off, wr_off;
  logic [BYTE_W-1:0] rd_data, wr_data;
  logic              wr_stb, sdo, oe;
  logic              lsb_r, rbsel_r;
  logic              soft_rst, commit, bank_we, rd_in_bank;
  logic [NUM_REGS*BYTE_W-1:0] buf_flat;

  assign sdio = oe ? sdo : 1'bz;

  dbuf_cfg_link #(.ADDR_W(ADDR_W)) link_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .csb_i(csb), .sdi_i(sdio),
    .lsb_first_i(lsb_r), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sdo_o(sdo), .oe_o(oe)
  );

  assign wr_off     = wr_addr - A_BASE;
  assign rd_off     = rd_addr - A_BASE;
  assign bank_we    = wr_stb && (wr_addr >= A_BASE) && (wr_off < A_NUM);
  assign rd_in_bank = (rd_addr >= A_BASE) && (rd_off < A_NUM);
  assign soft_rst   = wr_stb && (wr_addr == A_CTRL) && wr_data[5];
  assign commit     = wr_stb && (wr_addr == A_XFER) && wr_data[0];

  dbuf_cfg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DEFAULTS(REG_DEFAULTS)) bank_i (
    .clk(clk), .rst(rst), .clear_i(soft_rst), .wr_en_i(bank_we),
    .wr_idx_i(wr_off[IDX_W-1:0]), .wr_data_i(wr_data), .commit_i(commit),
    .buf_o(buf_flat), .act_o(active_o)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      lsb_r   <= 1'b0;
      rbsel_r <= 1'b0;
    end else if (wr_stb) begin
      if (wr_addr == A_CTRL)  lsb_r   <= wr_data[6];
      if (wr_addr == A_RBSEL) rbsel_r <= wr_data[0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_in_bank)
      rd_data = rbsel_r ? buf_flat[rd_off[IDX_W-1:0]*BYTE_W +: BYTE_W]
                        : active_o[rd_off[IDX_W-1:0]*BYTE_W +: BYTE_W];
    else if (rd_addr == A_CTRL)
      rd_data = {1'b0, lsb_r, 1'b0, 1'b1, 1'b1, 1'b0, lsb_r, 1'b0};
    else if (rd_addr == A_RBSEL)
      rd_data = {7'd0, rbsel_r};
  end

  // R7: fixed bits and mirrored nibble of the control register
  assert_ctrl_mirror_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_CTRL) |->
      (rd_data[3:0] == {rd_data[4], rd_data[5], rd_data[6], rd_data[7]}) &&
      !rd_data[7] && rd_data[4]);
  // R3: transfer register never reads back set
  assert_xfer_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_XFER) |-> rd_data == '0);
endmodule

// File: tb/dbuf_cfg_regs_tb.sv
module dbuf_cfg_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        csb = 1'b1;
  logic        tb_oe = 1'b0;
  logic        tb_bit = 1'b0;
  wire         sdio;
  logic [31:0] active;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_byte;
  event       rd_ev;

  assign sdio = tb_oe ? tb_bit : 1'bz;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbuf_cfg_regs dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .csb(csb), .sdio(sdio), .active_o(active)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // monitor: compares each completed read byte against the scoreboard
  initial forever begin
    @(rd_ev);
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R1 unexpected read byte: got %h expected none", got_byte);
    end else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      if (got_byte !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, got_byte, e);
      end
    end
  end

  task automatic bit_cycle(input logic b, input logic drive, output logic s);
    sclk   = 1'b0;
    tb_bit = b;
    tb_oe  = drive;
    repeat (HALF) @(negedge clk);
    s    = sdio;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic lsb, input logic rd, input logic [12:0] addr,
                      input int n, input logic [7:0] wd[8]);
    logic [15:0] word;
    logic        s;
    logic [7:0]  cap;
    word = {rd, 2'b00, addr};
    @(negedge clk);
    csb = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 16; i++) bit_cycle(lsb ? word[i] : word[15-i], 1'b1, s);
    for (int k = 0; k < n; k++) begin
      cap = '0;
      for (int i = 0; i < 8; i++) begin
        bit_cycle(lsb ? wd[k][i] : wd[k][7-i], !rd, s);
        cap = lsb ? {s, cap[7:1]} : {cap[6:0], s};
      end
      if (rd) begin
        got_byte = cap;
        -> rd_ev;
      end
    end
    tb_oe = 1'b0;
    sclk  = 1'b0;
    repeat (HALF) @(negedge clk);
    csb = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr(input logic lsb, input logic [12:0] addr, input int n, input logic [7:0] wd[8]);
    xfer(lsb, 1'b0, addr, n, wd);
  endtask

  // driver: queue the expected bytes, then run the read frame
  task automatic rd_exp(input logic lsb, input logic [12:0] addr, input int n,
                        input logic [7:0] ex[8], input string tag);
    logic [7:0] none[8] = '{default: 8'h00};
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(ex[k]);
      tag_q.push_back(tag);
    end
    xfer(lsb, 1'b1, addr, n, none);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    chk("R10 reset active values", active, 32'h0000_3080);
    tb_oe = 1'b1; tb_bit = 1'b0; repeat (4) @(negedge clk);
    chk("R9 idle line low", {31'd0, sdio}, 32'd0);
    tb_bit = 1'b1; repeat (4) @(negedge clk);
    chk("R9 idle line high", {31'd0, sdio}, 32'd1);
    tb_oe = 1'b0;

    rd_exp(1'b0, 13'h000, 1, '{8'h18, 0, 0, 0, 0, 0, 0, 0}, "R7 ctrl read msb mode");
    rd_exp(1'b0, 13'h004, 1, '{8'h00, 0, 0, 0, 0, 0, 0, 0}, "R4 selector default");
    rd_exp(1'b0, 13'h003, 1, '{8'h00, 0, 0, 0, 0, 0, 0, 0}, "R8 unused reads zero");

    wr(1'b0, 13'h00A, 2, '{8'h5C, 8'hA7, 0, 0, 0, 0, 0, 0});
    chk("R2 active unchanged after write", active, 32'h0000_3080);
    rd_exp(1'b0, 13'h00A, 1, '{8'h80, 0, 0, 0, 0, 0, 0, 0}, "R4 active readback");
    wr(1'b0, 13'h004, 1, '{8'h01, 0, 0, 0, 0, 0, 0, 0});
    rd_exp(1'b0, 13'h00A, 2, '{8'h5C, 8'hA7, 0, 0, 0, 0, 0, 0}, "R1 R4 staged stream read");
    wr(1'b0, 13'h005, 1, '{8'h01, 0, 0, 0, 0, 0, 0, 0});
    chk("R3 commit applied", active, 32'h0000_A75C);
    rd_exp(1'b0, 13'h005, 1, '{8'h00, 0, 0, 0, 0, 0, 0, 0}, "R3 transfer bit self clears");

    wr(1'b0, 13'h020, 1, '{8'hFF, 0, 0, 0, 0, 0, 0, 0});
    rd_exp(1'b0, 13'h020, 1, '{8'h00, 0, 0, 0, 0, 0, 0, 0}, "R8 write ignored");

    wr(1'b0, 13'h000, 1, '{8'h20, 0, 0, 0, 0, 0, 0, 0});
    chk("R6 soft reset active", active, 32'h0000_3080);
    rd_exp(1'b0, 13'h004, 1, '{8'h00, 0, 0, 0, 0, 0, 0, 0}, "R6 selector cleared");
    rd_exp(1'b0, 13'h000, 1, '{8'h18, 0, 0, 0, 0, 0, 0, 0}, "R6 soft reset bit reads zero");

    // set lsb-first and selector in one msb frame; selector byte must still be msb
    wr(1'b0, 13'h000, 5, '{8'h42, 8'h00, 8'h00, 8'h00, 8'h01, 0, 0, 0});
    rd_exp(1'b1, 13'h004, 1, '{8'h01, 0, 0, 0, 0, 0, 0, 0}, "R5 order change waits for next frame");
    rd_exp(1'b1, 13'h000, 1, '{8'h5A, 0, 0, 0, 0, 0, 0, 0}, "R7 ctrl read lsb mode");
    rd_exp(1'b1, 13'h00A, 1, '{8'h80, 0, 0, 0, 0, 0, 0, 0}, "R6 buffers restored");

    wr(1'b1, 13'h00B, 1, '{8'h3C, 0, 0, 0, 0, 0, 0, 0});
    chk("R2 lsb write staged only", active, 32'h0000_3080);
    wr(1'b1, 13'h005, 1, '{8'h01, 0, 0, 0, 0, 0, 0, 0});
    chk("R3 R5 lsb commit", active, 32'h0000_3C80);

    wr(1'b1, 13'h000, 1, '{8'h20, 0, 0, 0, 0, 0, 0, 0});
    rd_exp(1'b0, 13'h000, 1, '{8'h18, 0, 0, 0, 0, 0, 0, 0}, "R6 R5 order back to msb");
    chk("R6 active after lsb soft reset", active, 32'h0000_3080);

    chk("R1 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule